// File: doc/BRIEF.md
# Card Memory Window Translator

This block keeps five programmable memory windows for one card socket and turns host memory addresses into card addresses. Each window covers an inclusive range of 4 KB host pages. A host page inside an enabled window is moved into a 26-bit card space by adding the window's 14-bit page offset, and any carry out of the 14 bits is dropped. Along with the card address, the block returns the attributes of the winning window: whether the access goes to common or attribute memory, write protection, bus width, the zero-wait-state request and a 2-bit wait-state count.

Software programs each window through a small configuration port. Every window has a start, a stop and an offset register. A separate enable register holds one bit per window. A window has to be switched off before it is reprogrammed: register writes aimed at a window whose enable bit is set are dropped. Host requests are looked up in a single cycle and the response is registered, so it appears on the clock edge after the request. A write that lands in a write-protected window is reported as blocked and is not forwarded.

Top module: `cmw_translator`

## Requirements
- R1: After a synchronous active-low reset all window enable bits are clear and the response outputs are zero, so the first request after reset misses.
- R2: A request with page number addr[23:12] hits a window when start page <= page <= stop page, with both ends inclusive. The response (rsp_valid and its fields) appears on the clock edge after the one that samples req_valid, and only for requests that had req_valid set.
- R3: On a hit, rsp_card_addr[25:12] = (page + offset) mod 2^14 and rsp_card_addr[11:0] = req_addr[11:0].
- R4: When several enabled windows match, the one with the lowest number wins, and its number appears on rsp_win.
- R5: A window whose enable bit is clear never matches, whatever its range.
- R6: Field encoding of the configuration data.
  - Start register (cfg_sel=0): bits 11:0 are the page, bit 15 selects 16-bit width, bit 14 requests zero wait states.
  - Stop register (cfg_sel=1): bits 11:0 are the page, bits 15:14 are the wait-state count (0 to 3).
  - Offset register (cfg_sel=2): bits 13:0 are the page offset, bit 15 is write protect, bit 14 selects attribute memory.
  - Enable register (cfg_sel=3): bit i enables window i, and cfg_win is ignored.
  - On a hit, these fields drive rsp_wide, rsp_zero_ws, rsp_wait, rsp_wp and rsp_attr.
- R7: A hitting write to a window with write protect set raises rsp_blocked and keeps rsp_fwd low. Every other hit raises rsp_fwd and keeps rsp_blocked low.
- R8: Writes to the start, stop or offset register of a window whose enable bit is set are ignored, and so are writes naming a window number of 5 or more.
- R9: On a miss, rsp_hit, rsp_win, rsp_card_addr, all attribute outputs, rsp_fwd and rsp_blocked are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_win | input | 3 | Window number for start, stop or offset writes |
| cfg_sel | input | 2 | Register select: 0 start, 1 stop, 2 offset, 3 enable |
| cfg_data | input | 16 | Configuration write data |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | Host request is a write |
| req_addr | input | 24 | Host address |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_hit | output | 1 | Request matched an enabled window |
| rsp_win | output | 3 | Number of the winning window |
| rsp_card_addr | output | 26 | Translated card address |
| rsp_attr | output | 1 | Attribute memory selected |
| rsp_wp | output | 1 | Window is write protected |
| rsp_wide | output | 1 | 16-bit data width |
| rsp_zero_ws | output | 1 | Zero-wait-state request |
| rsp_wait | output | 2 | Wait-state count |
| rsp_fwd | output | 1 | Access may be forwarded to the card |
| rsp_blocked | output | 1 | Write refused by write protection |

## Verification
Two cases are hard to reach from the ports:
- A register write that lands while its window is enabled. The write leaves no trace unless a later request falls in the range that write would have created, so directed steps move a start page while the window is live, probe the new range, then disable, rewrite and probe again.
- A carry out of the 14-bit page sum. This only shows with a large offset, so an offset near the top of the range is placed over a high host page.

Random phases reprogram all windows with small, overlapping page ranges so that multi-window priority conflicts are frequent, and mix reads and writes against a reference model kept in the bench.

// File: rtl/cmw_pkg.sv
// Package: shared widths and types for the card memory window translator.
// Assumes 4 KB pages, a 24-bit host address and a 14-bit card page space.
package cmw_pkg;

    localparam int HOST_AW   = 24;
    localparam int PAGE_LSB  = 12;
    localparam int PAGE_W    = HOST_AW - PAGE_LSB;
    localparam int CPAGE_W   = 14;
    localparam int CARD_AW   = CPAGE_W + PAGE_LSB;
    localparam int CFG_W     = 16;
    localparam int WAIT_W    = 2;

    typedef enum logic [1:0] {
        SEL_START  = 2'd0,
        SEL_STOP   = 2'd1,
        SEL_OFFSET = 2'd2,
        SEL_ENABLE = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic [PAGE_W-1:0]  start_pg;
        logic               wide;
        logic               zero_ws;
        logic [PAGE_W-1:0]  stop_pg;
        logic [WAIT_W-1:0]  wait_cnt;
        logic [CPAGE_W-1:0] offs_pg;
        logic               wprot;
        logic               attr;
    } win_cfg_t;

endpackage

// File: rtl/cmw_win_regs.sv
// Module: configuration registers of one memory window.
// Decodes the start, stop and offset layouts into fields.
// Assumes the caller raises wr_en only for this window. Writes are dropped
// while locked is high (window enabled).
module cmw_win_regs
    import cmw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  cfg_sel_e         sel,
    input  logic [CFG_W-1:0] wr_data,
    input  logic             locked,
    output win_cfg_t         cfg
);

    // Load the selected register's fields when the window is unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_en && !locked) begin
            case (sel)
                SEL_START: begin
                    cfg.start_pg <= wr_data[PAGE_W-1:0];
                    cfg.wide     <= wr_data[15];
                    cfg.zero_ws  <= wr_data[14];
                end
                SEL_STOP: begin
                    cfg.stop_pg  <= wr_data[PAGE_W-1:0];
                    cfg.wait_cnt <= wr_data[15:14];
                end
                SEL_OFFSET: begin
                    cfg.offs_pg  <= wr_data[CPAGE_W-1:0];
                    cfg.wprot    <= wr_data[15];
                    cfg.attr     <= wr_data[14];
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/cmw_win_match.sv
// Module: range comparator for one window.
// Gives a hit when the window is enabled and the page lies in
// start..stop, both ends inclusive. A start above stop never hits.
module cmw_win_match
    import cmw_pkg::*;
(
    input  win_cfg_t          cfg,
    input  logic              enable,
    input  logic [PAGE_W-1:0] page,
    output logic              hit
);

    // Inclusive two-sided comparison gated by the enable bit.
    always_comb begin
        hit = enable && (page >= cfg.start_pg) && (page <= cfg.stop_pg);
    end

endmodule

// File: rtl/cmw_pick.sv
// Module: fixed-priority selector over the window hit vector.
// The lowest-numbered hitting window wins, and its config is muxed out.
// Assumes NUM_WIN >= 1.
module cmw_pick
    import cmw_pkg::*;
#(
    parameter  int NUM_WIN   = 5,
    localparam int WIN_IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic [NUM_WIN-1:0]   hit_vec,
    input  win_cfg_t             cfg_arr [NUM_WIN],
    output logic                 any_hit,
    output logic [WIN_IDX_W-1:0] win_idx,
    output win_cfg_t             win_cfg
);

    // Walk from the highest window downward so the lowest hit is kept last.
    always_comb begin
        any_hit = 1'b0;
        win_idx = '0;
        win_cfg = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                any_hit = 1'b1;
                win_idx = WIN_IDX_W'(i);
                win_cfg = cfg_arr[i];
            end
        end
    end

endmodule

// File: rtl/cmw_translator.sv
// Module: top of the card memory window translator.
// Holds the window enable register, one register set and one comparator
// per window, a priority pick, a single page-offset adder and a registered
// response stage. The response trails the request by one clock.
module cmw_translator
    import cmw_pkg::*;
#(
    parameter  int NUM_WIN   = 5,
    localparam int WIN_IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [WIN_IDX_W-1:0] cfg_win,
    input  logic [1:0]           cfg_sel,
    input  logic [CFG_W-1:0]     cfg_data,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [HOST_AW-1:0]   req_addr,
    output logic                 rsp_valid,
    output logic                 rsp_hit,
    output logic [WIN_IDX_W-1:0] rsp_win,
    output logic [CARD_AW-1:0]   rsp_card_addr,
    output logic                 rsp_attr,
    output logic                 rsp_wp,
    output logic                 rsp_wide,
    output logic                 rsp_zero_ws,
    output logic [WAIT_W-1:0]    rsp_wait,
    output logic                 rsp_fwd,
    output logic                 rsp_blocked
);

    cfg_sel_e             sel;
    logic [NUM_WIN-1:0]   win_en;
    logic [NUM_WIN-1:0]   hit_vec;
    win_cfg_t             cfg_arr [NUM_WIN];
    logic [PAGE_W-1:0]    host_pg;
    logic                 any_hit;
    logic [WIN_IDX_W-1:0] win_idx;
    win_cfg_t             win_cfg;
    logic [CPAGE_W-1:0]   card_pg;
    logic                 blocked;

    // Register select taken from the raw port bits.
    assign sel     = cfg_sel_e'(cfg_sel);
    assign host_pg = req_addr[HOST_AW-1:PAGE_LSB];

    // Enable register: one bit per window, written through the enable select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_en <= '0;
        end else if (cfg_we && sel == SEL_ENABLE) begin
            win_en <= cfg_data[NUM_WIN-1:0];
        end
    end

    // One register set and one comparator per window.
    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        logic sel_this;
        assign sel_this = cfg_we && (cfg_win == WIN_IDX_W'(g));

        cmw_win_regs u_regs (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (sel_this),
            .sel     (sel),
            .wr_data (cfg_data),
            .locked  (win_en[g]),
            .cfg     (cfg_arr[g])
        );

        cmw_win_match u_match (
            .cfg    (cfg_arr[g]),
            .enable (win_en[g]),
            .page   (host_pg),
            .hit    (hit_vec[g])
        );
    end

    cmw_pick #(.NUM_WIN(NUM_WIN)) u_pick (
        .hit_vec (hit_vec),
        .cfg_arr (cfg_arr),
        .any_hit (any_hit),
        .win_idx (win_idx),
        .win_cfg (win_cfg)
    );

    // Single page adder after selection, wrapping modulo the card page space.
    always_comb begin
        card_pg = CPAGE_W'(host_pg) + win_cfg.offs_pg;
        blocked = req_write && win_cfg.wprot;
    end

    // Response stage: capture the selected result, zero everything on a miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid     <= 1'b0;
            rsp_hit       <= 1'b0;
            rsp_win       <= '0;
            rsp_card_addr <= '0;
            rsp_attr      <= 1'b0;
            rsp_wp        <= 1'b0;
            rsp_wide      <= 1'b0;
            rsp_zero_ws   <= 1'b0;
            rsp_wait      <= '0;
            rsp_fwd       <= 1'b0;
            rsp_blocked   <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid && any_hit) begin
                rsp_hit       <= 1'b1;
                rsp_win       <= win_idx;
                rsp_card_addr <= {card_pg, req_addr[PAGE_LSB-1:0]};
                rsp_attr      <= win_cfg.attr;
                rsp_wp        <= win_cfg.wprot;
                rsp_wide      <= win_cfg.wide;
                rsp_zero_ws   <= win_cfg.zero_ws;
                rsp_wait      <= win_cfg.wait_cnt;
                rsp_fwd       <= !blocked;
                rsp_blocked   <= blocked;
            end else begin
                rsp_hit       <= 1'b0;
                rsp_win       <= '0;
                rsp_card_addr <= '0;
                rsp_attr      <= 1'b0;
                rsp_wp        <= 1'b0;
                rsp_wide      <= 1'b0;
                rsp_zero_ws   <= 1'b0;
                rsp_wait      <= '0;
                rsp_fwd       <= 1'b0;
                rsp_blocked   <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/cmw_translator_chk.sv
// Module: protocol checker for cmw_translator, attached with bind.
// Watches the ports plus the enable register and relates them over time.
module cmw_translator_chk
    import cmw_pkg::*;
#(
    parameter  int NUM_WIN   = 5,
    localparam int WIN_IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_write,
    input logic [HOST_AW-1:0]   req_addr,
    input logic [NUM_WIN-1:0]   win_en,
    input logic                 rsp_valid,
    input logic                 rsp_hit,
    input logic [WIN_IDX_W-1:0] rsp_win,
    input logic [CARD_AW-1:0]   rsp_card_addr,
    input logic                 rsp_wp,
    input logic                 rsp_fwd,
    input logic                 rsp_blocked
);

    // R2: a response follows exactly the cycles that carried a request.
    assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_no_rsp_without_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R3: the byte offset within the page passes through unchanged.
    assert_page_offset_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_card_addr[PAGE_LSB-1:0] == $past(req_addr[PAGE_LSB-1:0]));

    // R4: the winning window number is always an existing window.
    assert_win_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_valid && rsp_win < WIN_IDX_W'(NUM_WIN)));

    // R5: with every window disabled no request can hit.
    assert_all_disabled_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && win_en == '0) |=> !rsp_hit);

    // R7: a protected write is blocked and never forwarded.
    assert_wp_write_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit && rsp_wp && $past(req_write)) |-> (rsp_blocked && !rsp_fwd));
    assert_blocked_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_blocked |-> (rsp_hit && rsp_wp && !rsp_fwd));

    // R9: a miss leaves the address and the forwarding outputs at zero.
    assert_miss_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_card_addr == '0 && !rsp_fwd && !rsp_blocked));

endmodule

bind cmw_translator cmw_translator_chk #(.NUM_WIN(NUM_WIN)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .req_addr      (req_addr),
    .win_en        (win_en),
    .rsp_valid     (rsp_valid),
    .rsp_hit       (rsp_hit),
    .rsp_win       (rsp_win),
    .rsp_card_addr (rsp_card_addr),
    .rsp_wp        (rsp_wp),
    .rsp_fwd       (rsp_fwd),
    .rsp_blocked   (rsp_blocked)
);

// File: tb/cmw_translator_test.sv
// Bench: directed corner cases plus seeded random windows and requests,
// compared against a reference model of the requirements.
module cmw_translator_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [2:0]  cfg_win;
    logic [1:0]  cfg_sel;
    logic [15:0] cfg_data;
    logic        req_valid;
    logic        req_write;
    logic [23:0] req_addr;
    logic        rsp_valid, rsp_hit, rsp_attr, rsp_wp, rsp_wide, rsp_zero_ws;
    logic        rsp_fwd, rsp_blocked;
    logic [2:0]  rsp_win;
    logic [25:0] rsp_card_addr;
    logic [1:0]  rsp_wait;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference model state.
    logic [15:0] m_start [5];
    logic [15:0] m_stop  [5];
    logic [15:0] m_offs  [5];
    logic [4:0]  m_en;

    always #4 clk = ~clk;

    cmw_translator uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_win(cfg_win),
        .cfg_sel(cfg_sel), .cfg_data(cfg_data), .req_valid(req_valid),
        .req_write(req_write), .req_addr(req_addr), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_win(rsp_win), .rsp_card_addr(rsp_card_addr),
        .rsp_attr(rsp_attr), .rsp_wp(rsp_wp), .rsp_wide(rsp_wide),
        .rsp_zero_ws(rsp_zero_ws), .rsp_wait(rsp_wait), .rsp_fwd(rsp_fwd),
        .rsp_blocked(rsp_blocked)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Expected response packed as {hit,win,card,attr,wp,wide,zws,wait,fwd,blocked}.
    function automatic logic [37:0] expect_rsp(input logic [23:0] a, input logic wr);
        logic [11:0] pg;
        pg = a[23:12];
        for (int i = 0; i < 5; i++) begin
            if (m_en[i] && pg >= m_start[i][11:0] && pg <= m_stop[i][11:0]) begin
                logic [13:0] cp;
                logic bl;
                cp = 14'(pg) + m_offs[i][13:0];
                bl = wr && m_offs[i][15];
                return {1'b1, 3'(i), cp, a[11:0], m_offs[i][14], m_offs[i][15],
                        m_start[i][15], m_start[i][14], m_stop[i][15:14], !bl, bl};
            end
        end
        return '0;
    endfunction

    function automatic logic [37:0] actual_rsp();
        return {rsp_hit, rsp_win, rsp_card_addr, rsp_attr, rsp_wp, rsp_wide,
                rsp_zero_ws, rsp_wait, rsp_fwd, rsp_blocked};
    endfunction

    task automatic cfg(input int w, input int s, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_win = 3'(w); cfg_sel = 2'(s); cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (s == 3) m_en = d[4:0];
        else if (w < 5 && !m_en[w]) begin
            if (s == 0) m_start[w] = d;
            else if (s == 1) m_stop[w] = d;
            else m_offs[w] = d;
        end
    endtask

    task automatic req(input string tag, input logic [23:0] a, input logic wr);
        logic [37:0] e;
        e = expect_rsp(a, wr);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " valid"}, 64'(rsp_valid), 64'(1'b1));
        check(tag, 64'(actual_rsp()), 64'(e));
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_win = '0; cfg_sel = '0; cfg_data = '0;
        req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
        m_en = '0;
        for (int i = 0; i < 5; i++) begin m_start[i] = '0; m_stop[i] = '0; m_offs[i] = '0; end
        repeat (3) @(negedge clk);
        check("R1 reset outputs", 64'(actual_rsp()), 64'(0));
        check("R1 reset valid", 64'(rsp_valid), 64'(0));
        rst_n = 1'b1;
        req("R1 miss after reset", 24'h000123, 1'b0);

        // Window 0: pages 0x010..0x01F, wide, wait 2, attr, offset 0x100.
        cfg(0, 0, 16'h8010);
        cfg(0, 1, 16'h801F);
        cfg(0, 2, 16'h4100);
        cfg(0, 3, 16'h0001);
        req("R2 start boundary", 24'h010ABC, 1'b0);
        req("R2 stop boundary R6", 24'h01FFFF, 1'b1);
        req("R9 below start", 24'h00FFFF, 1'b0);
        req("R9 above stop", 24'h020000, 1'b0);

        // Window 2: pages 0x018..0x030, write protected, zero-ws, wait 1, big offset.
        cfg(2, 0, 16'h4018);
        cfg(2, 1, 16'h4030);
        cfg(2, 2, 16'hBFF0);
        cfg(0, 3, 16'h0005);
        req("R4 overlap lowest wins", 24'h018004, 1'b1);
        req("R3 page wrap", 24'h025777, 1'b0);
        req("R7 protected write blocked", 24'h025010, 1'b1);
        req("R6 fields window2", 24'h030FFF, 1'b0);

        // Lock: writes to an enabled window are dropped.
        cfg(0, 0, 16'h0000);
        req("R8 locked write ignored", 24'h005000, 1'b0);
        cfg(6, 0, 16'h0000);
        req("R8 out of range window", 24'h005000, 1'b0);
        cfg(0, 3, 16'h0004);
        req("R5 disabled window skipped", 24'h018000, 1'b0);
        req("R5 disabled window miss", 24'h011000, 1'b0);
        cfg(0, 0, 16'h0000);
        cfg(0, 3, 16'h0005);
        req("R8 unlocked write applied", 24'h005000, 1'b0);

        // Random phase: fixed seed, small overlapping ranges.
        void'($urandom(32'h5eed_c0de));
        for (int round = 0; round < 12; round++) begin
            cfg(0, 3, 16'h0000);
            for (int w = 0; w < 5; w++) begin
                logic [11:0] s;
                s = 12'($urandom_range(0, 48));
                cfg(w, 0, {2'($urandom), 2'b00, s});
                cfg(w, 1, {2'($urandom), 2'b00, s + 12'($urandom_range(0, 20))});
                cfg(w, 2, {2'($urandom), 14'($urandom)});
            end
            cfg(0, 3, 16'($urandom_range(0, 31)));
            for (int k = 0; k < 40; k++) begin
                req("R4 random", {12'($urandom_range(0, 80)), 12'($urandom)}, 1'($urandom));
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule